// File: doc/BRIEF.md
# Peripheral input routing matrix

This block chooses, for every peripheral input signal of a chip, where that signal's value comes from. Each peripheral signal has one small configuration word. The word holds a source select, an inversion flag and a route flag. When the route flag is set, the select picks one of the external pin values or a fixed level, and the inversion flag may flip the result. When the route flag is clear, the signal skips the matrix and takes its value from a dedicated direct input, which the pad multiplexer feeds.

Software sets the configuration words through a simple word-addressed write/read port. The words sit at byte address `BASE_ADDR + 4*i` for signal `i`. Pin values and direct inputs pass to the outputs without any register in the path. A configuration write therefore changes the routing from the first clock edge after it is accepted. Synchronising the pin values and multiplexing the pads are done by other blocks.

Top module: `rmx_input_matrix`

## Requirements
- R1: With the route flag set (bit 7 = 1) and a select value (bits 5:0) from 0 to NUM_PIN-1 (default 39), the output of that signal equals `pin_in[select]`, XORed with the inversion flag (bit 6).
- R2: With the route flag set and select 0x38, the output is constantly high when the inversion flag is 0 and constantly low when it is 1.
- R3: With the route flag set and select 0x30, the output is constantly low when the inversion flag is 0 and constantly high when it is 1.
- R4: With the route flag set and a select that is neither a pin number nor one of the two level codes (for example 40, 47, 49 or 0x3F), the routed value is low before inversion.
- R5: The inversion flag is applied after the select for every kind of source: pin, level code or unused code.
- R6: With the route flag clear, the output equals `direct_in[i]`, and the inversion flag and the select have no effect.
- R7: After reset every configuration word reads 0, which means bypass, select 0 and no inversion. Every output then follows its direct input.
- R8: A write or read is accepted only at a byte address `BASE_ADDR + 4*i` (default base 0x130) with `i < NUM_SIG`. A write to an unaligned, lower or higher address changes no configuration word. A read from such an address returns 0.
- R9: A read returns the stored select in bits 5:0, the inversion flag in bit 6 and the route flag in bit 7, with bits 31:8 zero. Write data bits 31:8 are discarded. `cfg_rdata` carries the result from the clock edge that samples `cfg_re` and holds it until the next accepted read strobe.
- R10: A write sampled on a rising clock edge sets the output routing from that edge onward. A change on `pin_in` or `direct_in` reaches `periph_in` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Byte address of the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_PIN | Synchronised external pin values |
| direct_in | input | NUM_SIG | Direct pad-multiplexer value for each signal |
| periph_in | output | NUM_SIG | Routed peripheral input values |

## Verification
There are three timing cases. A change on the pin or direct inputs reaches the outputs in the same cycle. A configuration write shows at the outputs one rising edge after the write strobe is sampled. Read data appears one rising edge after the read strobe. The bench drives every stimulus on a falling edge and samples shortly after the next falling edge. At that point exactly one rising edge has passed, so each result is already due and is still stable. A bench model holds the expected configuration words and works out every output bit from the requirement text. The stimulus is a seeded random mix, plus directed cases for each pin, each level code, unused codes, bypass with inversion set, and addresses outside the window.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

  localparam int SEL_W  = 6;
  localparam int WORD_W = 32;

  localparam logic [SEL_W-1:0] CODE_HIGH = 6'h38;
  localparam logic [SEL_W-1:0] CODE_LOW  = 6'h30;

  // Configuration word layout: route at bit 7, invert at bit 6, select at 5:0
  typedef struct packed {
    logic             route;
    logic             inv;
    logic [SEL_W-1:0] sel;
  } rmx_cfg_t;

  localparam int CFG_W = $bits(rmx_cfg_t);

  localparam rmx_cfg_t CFG_RESET = '{route: 1'b0, inv: 1'b0, sel: '0};

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_HIGH = 2'd1,
    SRC_LOW  = 2'd2,
    SRC_NONE = 2'd3
  } rmx_src_e;

  // Sort a select code into its source kind for a given pin count
  function automatic rmx_src_e rmx_classify(logic [SEL_W-1:0] s, int unsigned npin);
    rmx_src_e k;
    if (32'(s) < npin)       k = SRC_PIN;
    else if (s == CODE_HIGH) k = SRC_HIGH;
    else if (s == CODE_LOW)  k = SRC_LOW;
    else                     k = SRC_NONE;
    return k;
  endfunction

  // Level driven by a non-pin source kind
  function automatic logic rmx_level(rmx_src_e k);
    return (k == SRC_HIGH);
  endfunction

  // Inversion stage applied after selection
  function automatic logic rmx_shape(logic raw, logic inv);
    return raw ^ inv;
  endfunction

  function automatic logic [WORD_W-1:0] rmx_pack(rmx_cfg_t c);
    return {{(WORD_W-CFG_W){1'b0}}, c};
  endfunction

  function automatic rmx_cfg_t rmx_unpack(logic [CFG_W-1:0] w);
    return rmx_cfg_t'(w);
  endfunction

endpackage

// File: rtl/rmx_addr_dec.sv
module rmx_addr_dec #(
  parameter int          NUM_SIG   = 16,
  parameter int          ADDR_W    = 12,
  parameter int          IDX_W     = 4,
  parameter logic [11:0] BASE_ADDR = 12'h130
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam int WORD_SPAN = NUM_SIG * 4;

  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] offset;
  logic              above_base;
  logic              aligned;
  logic              in_span;

  assign base_w     = ADDR_W'(BASE_ADDR);
  assign above_base = (addr >= base_w);
  assign offset     = addr - base_w;
  assign aligned    = (offset[1:0] == 2'b00);
  assign in_span    = (32'(offset) < WORD_SPAN);
  assign hit        = above_base && aligned && in_span;
  assign idx        = offset[IDX_W+1:2];

  // R8: a hit must always point at an existing configuration word
  always_comb begin
    if (hit) begin
      AST_IDX_IN_RANGE: assert (32'(idx) < NUM_SIG); // R8
    end
  end

endmodule

// File: rtl/rmx_cfg_bank.sv
module rmx_cfg_bank
  import rmx_pkg::*;
#(
  parameter int NUM_SIG = 16,
  parameter int IDX_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic                    re,
  input  logic                    hit,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORD_W-1:0]       rdata,
  output rmx_cfg_t [NUM_SIG-1:0]  cfg_q
);

  logic                    wr_hit;
  logic                    rd_hit;
  rmx_cfg_t                wr_word;
  logic [NUM_SIG-1:0]      wr_sel;
  logic                    unused_wdata_hi;

  assign wr_hit          = we && hit;
  assign rd_hit          = re && hit;
  assign wr_word         = rmx_unpack(wdata[CFG_W-1:0]);
  assign unused_wdata_hi = ^wdata[WORD_W-1:CFG_W];

  generate
    for (genvar g = 0; g < NUM_SIG; g++) begin : g_word
      assign wr_sel[g] = wr_hit && (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_q[g] <= CFG_RESET;
        else if (wr_sel[g]) cfg_q[g] <= wr_word;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (re)     rdata <= rd_hit ? rmx_pack(cfg_q[idx]) : '0;
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R8

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cfg_q[$past(idx)] == $past(wr_word))); // R10

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(cfg_q)); // R8

  AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !hit) |=> (rdata == '0)); // R8

  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> (rdata[WORD_W-1:CFG_W] == '0)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata)); // R9

endmodule

// File: rtl/rmx_sig_route.sv
module rmx_sig_route
  import rmx_pkg::*;
#(
  parameter int NUM_SIG = 16,
  parameter int NUM_PIN = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  rmx_cfg_t [NUM_SIG-1:0] cfg_q,
  input  logic [NUM_PIN-1:0]     pin_in,
  input  logic [NUM_SIG-1:0]     direct_in,
  output logic [NUM_SIG-1:0]     periph_in
);

  // Pin multiplexer written as a compare loop so that out-of-range codes read nothing
  function automatic logic pick_pin(logic [NUM_PIN-1:0] pins, logic [SEL_W-1:0] s);
    logic v;
    v = 1'b0;
    for (int p = 0; p < NUM_PIN; p++) begin
      if (s == SEL_W'(p)) v = pins[p];
    end
    return v;
  endfunction

  generate
    for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
      rmx_src_e src_kind;
      logic     pin_val;
      logic     raw_val;
      logic     matrix_val;
      logic     via_matrix;

      assign src_kind   = rmx_classify(cfg_q[g].sel, NUM_PIN);
      assign pin_val    = pick_pin(pin_in, cfg_q[g].sel);
      assign raw_val    = (src_kind == SRC_PIN) ? pin_val : rmx_level(src_kind);
      assign matrix_val = rmx_shape(raw_val, cfg_q[g].inv);
      assign via_matrix = cfg_q[g].route;
      assign periph_in[g] = via_matrix ? matrix_val : direct_in[g];

      AST_PIN_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (via_matrix && (32'(cfg_q[g].sel) < NUM_PIN))
          |-> (periph_in[g] == (pin_in[cfg_q[g].sel] ^ cfg_q[g].inv))); // R1

      AST_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (via_matrix && (cfg_q[g].sel == CODE_HIGH))
          |-> (periph_in[g] == !cfg_q[g].inv)); // R2

      AST_CONST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (via_matrix && (cfg_q[g].sel == CODE_LOW))
          |-> (periph_in[g] == cfg_q[g].inv)); // R3

      AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (via_matrix && (src_kind == SRC_NONE))
          |-> (periph_in[g] == cfg_q[g].inv)); // R4

      AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !via_matrix |-> (periph_in[g] == direct_in[g])); // R6
    end
  endgenerate

endmodule

// File: rtl/rmx_input_matrix.sv
module rmx_input_matrix
  import rmx_pkg::*;
#(
  parameter int          NUM_SIG   = 16,
  parameter int          NUM_PIN   = 40,
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] BASE_ADDR = 12'h130
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_PIN-1:0] pin_in,
  input  logic [NUM_SIG-1:0] direct_in,
  output logic [NUM_SIG-1:0] periph_in
);

  localparam int IDX_W = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1;

  logic                   addr_hit;
  logic [IDX_W-1:0]       addr_idx;
  rmx_cfg_t [NUM_SIG-1:0] cfg_q;

  rmx_addr_dec #(
    .NUM_SIG  (NUM_SIG),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(cfg_addr),
    .hit (addr_hit),
    .idx (addr_idx)
  );

  rmx_cfg_bank #(
    .NUM_SIG(NUM_SIG),
    .IDX_W  (IDX_W)
  ) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .re   (cfg_re),
    .hit  (addr_hit),
    .idx  (addr_idx),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .cfg_q(cfg_q)
  );

  rmx_sig_route #(
    .NUM_SIG(NUM_SIG),
    .NUM_PIN(NUM_PIN)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_q    (cfg_q),
    .pin_in   (pin_in),
    .direct_in(direct_in),
    .periph_in(periph_in)
  );

  // R7: the first cycle out of reset sees every signal on its direct path
  AST_RESET_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (periph_in == direct_in)); // R7

endmodule

// File: tb/test_rmx_input_matrix.sv
module test_rmx_input_matrix;

  localparam int          CLK_PERIOD = 10;
  localparam int          NS   = 16;
  localparam int          NP   = 40;
  localparam int          AW   = 12;
  localparam logic [11:0] BASE = 12'h130;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_re = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NS-1:0] direct_in = '0;
  logic [NS-1:0] periph_in;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [5:0] m_sel   [NS];
  logic       m_inv   [NS];
  logic       m_route [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmx_input_matrix #(
    .NUM_SIG(NS), .NUM_PIN(NP), .ADDR_W(AW), .BASE_ADDR(BASE)
  ) i_rmx_input_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pin_in(pin_in), .direct_in(direct_in), .periph_in(periph_in)
  );

  function automatic logic [AW-1:0] sig_addr(int i);
    return AW'(BASE) + AW'(4 * i);
  endfunction

  function automatic bit addr_ok(logic [AW-1:0] a);
    if (a < AW'(BASE)) return 1'b0;
    if (((a - AW'(BASE)) % 4) != 0) return 1'b0;
    return ((a - AW'(BASE)) / 4) < NS;
  endfunction

  // Expected output bit restated from R1..R6
  function automatic logic exp_out(int i);
    logic v;
    if (!m_route[i]) return direct_in[i];
    if (m_sel[i] < 6'(NP))     v = pin_in[m_sel[i]];
    else if (m_sel[i] == 6'h38) v = 1'b1;
    else                        v = 1'b0;
    return m_inv[i] ? ~v : v;
  endfunction

  function automatic logic [31:0] exp_word(int i);
    return {24'd0, m_route[i], m_inv[i], m_sel[i]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    #1;
    for (int i = 0; i < NS; i++) check(req, 32'(periph_in[i]), 32'(exp_out(i)));
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr_ok(a)) begin
      int k;
      k = int'((a - AW'(BASE)) / 4);
      m_sel[k] = d[5:0]; m_inv[k] = d[6]; m_route[k] = d[7];
    end
  endtask

  task automatic do_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    #1 d = cfg_rdata;
  endtask

  task automatic set_inputs(logic [NP-1:0] p, logic [NS-1:0] dd);
    @(negedge clk);
    pin_in = p; direct_in = dd;
  endtask

  function automatic logic [NP-1:0] rnd_pins();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NS; i++) begin
      m_sel[i] = '0; m_inv[i] = 1'b0; m_route[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: reset state
    for (int i = 0; i < NS; i++) begin
      do_read(sig_addr(i), rd);
      check("R7 reset word", rd, 32'd0);
    end
    set_inputs(40'hA5_5A5A_A5A5, 16'hC3A5);
    check_outputs("R7 bypass after reset");

    // R1: walk each pin on signal 3, with and without inversion
    for (int p = 0; p < NP; p++) begin
      do_write(sig_addr(3), 32'h80 | 32'(p) | ((p % 2) ? 32'h40 : 32'h0));
      set_inputs(NP'(1) << p, '0);
      check_outputs("R1 pin select one-hot");
      set_inputs(~(NP'(1) << p), '1);
      check_outputs("R1 pin select zero-hot");
    end

    // R2, R3, R5: level codes with both inversions
    do_write(sig_addr(5), 32'h0000_00B8);
    do_write(sig_addr(6), 32'h0000_00F8);
    do_write(sig_addr(7), 32'h0000_00B0);
    do_write(sig_addr(8), 32'h0000_00F0);
    set_inputs('1, '0);
    check_outputs("R2 R3 R5 level codes, pins high");
    set_inputs('0, '1);
    check_outputs("R2 R3 R5 level codes, pins low");

    // R4, R5: unused codes
    do_write(sig_addr(9),  32'h0000_00A8); // 40
    do_write(sig_addr(10), 32'h0000_00EF); // 47, inverted
    do_write(sig_addr(11), 32'h0000_00B1); // 49
    do_write(sig_addr(12), 32'h0000_00FF); // 0x3F, inverted
    set_inputs('1, '0);
    check_outputs("R4 R5 unused codes");

    // R6: bypass ignores invert and select
    do_write(sig_addr(13), 32'h0000_0078);
    set_inputs(rnd_pins(), 16'h2000);
    check_outputs("R6 bypass with invert set");
    set_inputs(rnd_pins(), 16'h0000);
    check_outputs("R6 bypass follows direct");

    // R8: writes outside the window change nothing; reads there return 0
    do_write(sig_addr(0) + AW'(1), 32'h0000_00FF);
    do_write(sig_addr(0) - AW'(4), 32'h0000_00FF);
    do_write(sig_addr(NS), 32'h0000_00FF);
    do_read(sig_addr(0), rd);
    check("R8 word 0 untouched", rd, exp_word(0));
    do_read(sig_addr(NS - 1), rd);
    check("R8 last word untouched", rd, exp_word(NS - 1));
    do_read(sig_addr(NS), rd);
    check("R8 read beyond window", rd, 32'd0);
    do_read(sig_addr(2) + AW'(2), rd);
    check("R8 unaligned read", rd, 32'd0);
    check_outputs("R8 outputs after stray writes");

    // R9: field positions, upper bits discarded
    do_write(sig_addr(NS - 1), 32'hFFFF_FF5A);
    do_read(sig_addr(NS - 1), rd);
    check("R9 readback fields", rd, 32'h0000_005A);
    @(negedge clk);
    #1 check("R9 rdata holds", cfg_rdata, 32'h0000_005A);

    // R10: same-cycle input response, next-edge config response
    do_write(sig_addr(1), 32'h0000_0080 | 32'd17);
    set_inputs(NP'(1) << 17, '0);
    check_outputs("R10 config at next edge");
    @(negedge clk);
    pin_in = '0;
    check_outputs("R10 pin change same cycle");

    // Random mix, R1..R6 and R9
    for (int it = 0; it < 400; it++) begin
      int k;
      int pick;
      logic [31:0] d;
      k = int'($urandom_range(NS - 1));
      pick = int'($urandom_range(9));
      d = $urandom;
      if (pick < 6)       d[5:0] = 6'($urandom_range(NP - 1));
      else if (pick == 6) d[5:0] = 6'h38;
      else if (pick == 7) d[5:0] = 6'h30;
      do_write(sig_addr(k), d);
      set_inputs(rnd_pins(), 16'($urandom));
      check_outputs("R1 R2 R3 R4 R5 R6 random");
      if ((it % 8) == 0) begin
        do_read(sig_addr(k), rd);
        check("R9 random readback", rd, exp_word(k));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule